// File: doc/BRIEF.md
# Pattern Block Sequencer

This block decides the order in which stretches of pattern memory are played out. A small program of sequence lines sits in an internal register array; each line either plays one block (a contiguous address range of pattern memory described in a block table), calls a short sub-program of lines, or ends the run. A played line carries a repeat count, an optional gate that holds playback until an event expression over eight external event inputs is true, a level for one selectable inter-module control signal, and a jump that is either absent, unconditional, or taken when a second event expression is true. Event expressions are held as 256-bit truth tables indexed directly by the event bus.

Per output clock the block presents a pattern-memory read address with a valid strobe. A start pulse runs the program from line 0; a stop input, an end line or a call made from inside a sub-program halts it. In step mode a manual pulse satisfies whatever gate or jump condition is being examined, so the program's flow can be walked through by hand. Programs, block entries and truth tables are loaded through a single write port while the sequencer is idle.

The controller has four states: IDLE (halted), FETCH (decode the line at the program counter), WAIT (hold until the gate condition is met) and PLAY (emit addresses). Transitions: IDLE to FETCH on start; FETCH to PLAY for a block line without a gate, FETCH to WAIT for a gated block line, FETCH to FETCH for a call, FETCH to IDLE for an end line or a nested call; WAIT to PLAY when the gate opens; PLAY to FETCH after the final vector of the final repeat; any state to IDLE on stop.

Top module: `sbs_sequencer`

## Requirements
- R1: After reset pat_valid, running, im_sig and nest_err are all 0; a start pulse while idle begins execution at line 0.
- R2: A block line emits its block's addresses base, base+1, ... base+len-1 on consecutive cycles with pat_valid high; a block entry is written with wr_kind=1, wr_addr[2:0] = block id, wr_data[7:0] = base and wr_data[15:8] = len-1.
- R3: A block line plays its block rpt+1 times (1 to 65,536) back to back before the next line is fetched.
- R4: A line with the infinite flag set replays its block until stop is asserted.
- R5: Line words are written with wr_kind=0, wr_addr[3:0] = line; fields: [1:0] kind (0 block, 1 call, 2 end), [2] return, [3] signal level, [4] gate enable, [6:5] gate table, [8:7] jump mode (0 none, 1 always, 2 if), [10:9] jump table, [11] infinite, [27:12] rpt, [31:28] block id or call target, [35:32] jump target. Lines run in ascending order and an end line halts the run with running and pat_valid low.
- R6: A gated line emits nothing until its truth table yields 1 for the current event value; tables are written with wr_kind=2, wr_addr[6:5] = table, wr_addr[4:0] = byte b, and bit j of wr_data[7:0] gives the result for event value 8*b+j.
- R7: A conditional jump is examined only at the last vector of the final repeat; if its table yields 1 the next line is the jump target, otherwise the following line.
- R8: An unconditional jump always continues at its target, so a once-only prologue followed by an endless loop can be built.
- R9: While running, im_sig has exactly the bit selected by sig_sel set when the playing line's level is 1 and is all zero otherwise; it is all zero when idle.
- R10: With step_mode high, step_go high satisfies a pending gate or conditional jump; with step_mode low, step_go has no effect.
- R11: A call line runs lines from its target until a line with the return flag completes, then resumes at the line after the call.
- R12: A call made from inside a sub-program sets nest_err and halts; the next start clears nest_err.
- R13: Stop halts the run from any state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for program storage |
| wr_kind | input | 2 | Target store: 0 line, 1 block, 2 truth table |
| wr_addr | input | 7 | Write address within the target store |
| wr_data | input | 36 | Write data |
| start | input | 1 | Begin execution at line 0 |
| stop | input | 1 | Halt execution |
| step_mode | input | 1 | Enable manual condition override |
| step_go | input | 1 | Manual override pulse |
| evt | input | 8 | External event inputs |
| sig_sel | input | 2 | Which inter-module signal the program drives |
| pat_addr | output | 8 | Pattern memory read address |
| pat_valid | output | 1 | Address valid strobe |
| im_sig | output | 4 | Inter-module control signals |
| running | output | 1 | Program executing |
| nest_err | output | 1 | Nested call detected |

## Verification
The address stream is compared as a whole against sequences assembled from block lengths and repeat counts, so a single missing, doubled or misordered vector shows. Conditional jumps are run with an event value matching the table, one missing only the tested bit and one with every other bit set, which separates correct table indexing from decoding of a single event bit. Gates are held closed with a near-miss event value and with a manual pulse while step mode is off, then opened by the exact value or by step mode. The call test distinguishes a correct return point from a fall-through, a 65,536-fold repeat checks the top of the count range, and the nested call and stop tests confirm halting from the call path and from endless loops.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int LINE_AW = 4;
    localparam int BLK_AW  = 3;
    localparam int PAT_AW  = 8;
    localparam int RPT_W   = 16;
    localparam int EVT_W   = 8;
    localparam int COND_AW = 2;
    localparam int SIG_N   = 4;
    localparam int SIG_AW  = $clog2(SIG_N);
    localparam int WADDR_W = COND_AW + EVT_W - 3;
    localparam int LINE_W  = 2 + 1 + 1 + 1 + COND_AW + 2 + COND_AW + 1 + RPT_W + 2 * LINE_AW;

    typedef enum logic [1:0] {K_BLOCK = 2'd0, K_CALL = 2'd1, K_END = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [1:0] {J_NONE = 2'd0, J_ALWAYS = 2'd1, J_IF = 2'd2, J_RSVD = 2'd3} jmode_e;
    typedef enum logic [1:0] {S_IDLE = 2'd0, S_FETCH = 2'd1, S_WAIT = 2'd2, S_PLAY = 2'd3} state_e;

    localparam logic [1:0] WR_LINE = 2'd0;
    localparam logic [1:0] WR_BLK  = 2'd1;
    localparam logic [1:0] WR_COND = 2'd2;

    typedef struct packed {
        logic [LINE_AW-1:0] jtgt;
        logic [LINE_AW-1:0] callee;
        logic [RPT_W-1:0]   rpt;
        logic               inf;
        logic [COND_AW-1:0] jsel;
        jmode_e             jmode;
        logic [COND_AW-1:0] wsel;
        logic               wen;
        logic               lvl;
        logic               ret;
        kind_e              kind;
    } line_t;

    typedef struct packed {
        logic [PAT_AW-1:0] len_m1;
        logic [PAT_AW-1:0] base;
    } blk_t;
endpackage

// File: rtl/sbs_line_store.sv
module sbs_line_store
    import sbs_pkg::*;
#(
    parameter int NUM_LINES = 1 << LINE_AW,
    parameter int NUM_BLKS  = 1 << BLK_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_kind,
    input  logic [LINE_AW-1:0] wr_addr,
    input  logic [LINE_W-1:0]  wr_data,
    input  logic [LINE_AW-1:0] rd_line_idx,
    output line_t              rd_line,
    input  logic [BLK_AW-1:0]  rd_blk_idx,
    output blk_t               rd_blk
);
    line_t lines [NUM_LINES];
    blk_t  blks  [NUM_BLKS];

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines[gi] <= '0;
            end else if (wr_en && wr_kind == WR_LINE && wr_addr == LINE_AW'(gi)) begin
                lines[gi] <= line_t'(wr_data);
            end
        end
    end

    for (genvar gb = 0; gb < NUM_BLKS; gb++) begin : g_blk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                blks[gb] <= '0;
            end else if (wr_en && wr_kind == WR_BLK && wr_addr[BLK_AW-1:0] == BLK_AW'(gb)) begin
                blks[gb] <= blk_t'(wr_data[2*PAT_AW-1:0]);
            end
        end
    end

    assign rd_line = lines[rd_line_idx];
    assign rd_blk  = blks[rd_blk_idx];
endmodule

// File: rtl/sbs_cond_eval.sv
module sbs_cond_eval
    import sbs_pkg::*;
#(
    parameter int NUM_COND = 1 << COND_AW,
    parameter int NQ       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_kind,
    input  logic [WADDR_W-1:0]           wr_addr,
    input  logic [7:0]                   wr_data,
    input  logic [EVT_W-1:0]             evt,
    input  logic                         force_hit,
    input  logic [NQ-1:0][COND_AW-1:0]   q_sel,
    output logic [NQ-1:0]                q_hit
);
    localparam int TT_BITS = 1 << EVT_W;
    localparam int BYTE_AW = EVT_W - 3;

    logic [TT_BITS-1:0] tables [NUM_COND];

    for (genvar gc = 0; gc < NUM_COND; gc++) begin : g_tab
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tables[gc] <= '0;
            end else if (wr_en && wr_kind == WR_COND &&
                         wr_addr[WADDR_W-1:BYTE_AW] == COND_AW'(gc)) begin
                tables[gc][wr_addr[BYTE_AW-1:0]*8 +: 8] <= wr_data;
            end
        end
    end

    for (genvar gq = 0; gq < NQ; gq++) begin : g_q
        assign q_hit[gq] = tables[q_sel[gq]][evt] | force_hit;
    end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  line_t              line,
    input  blk_t               blk,
    input  logic               wait_hit,
    input  logic               jump_hit,
    output logic [LINE_AW-1:0] line_idx,
    output logic [BLK_AW-1:0]  blk_idx,
    output logic [COND_AW-1:0] wait_sel,
    output logic [COND_AW-1:0] jump_sel,
    output logic [PAT_AW-1:0]  pat_addr,
    output logic               pat_valid,
    output logic               lvl,
    output logic               running,
    output logic               nest_err
);
    state_e             state, nxt;
    logic [LINE_AW-1:0] pc, ret_pc, cur_jtgt;
    logic               in_sub, cur_ret, cur_inf;
    logic [RPT_W-1:0]   cur_rpt, rcnt;
    jmode_e             cur_jmode;
    logic [PAT_AW-1:0]  base, len_m1, vcnt, paddr;
    logic               last_vec, last_rep, take_jump;

    assign last_vec  = (vcnt == '0);
    assign last_rep  = !cur_inf && (rcnt == cur_rpt);
    assign take_jump = (cur_jmode == J_ALWAYS) || (cur_jmode == J_IF && jump_hit);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_FETCH;
            S_FETCH: begin
                unique case (line.kind)
                    K_BLOCK: nxt = line.wen ? S_WAIT : S_PLAY;
                    K_CALL:  nxt = in_sub ? S_IDLE : S_FETCH;
                    K_END:   nxt = S_IDLE;
                    K_RSVD:  nxt = S_IDLE;
                endcase
            end
            S_WAIT:  if (wait_hit) nxt = S_PLAY;
            S_PLAY:  if (last_vec && last_rep) nxt = S_FETCH;
        endcase
        if (stop) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0; ret_pc <= '0; in_sub <= 1'b0; nest_err <= 1'b0; lvl <= 1'b0;
            cur_jtgt <= '0; cur_ret <= 1'b0; cur_inf <= 1'b0; cur_rpt <= '0; cur_jmode <= J_NONE;
            wait_sel <= '0; jump_sel <= '0;
            base <= '0; len_m1 <= '0; vcnt <= '0; paddr <= '0; rcnt <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        pc <= '0; in_sub <= 1'b0; nest_err <= 1'b0; lvl <= 1'b0;
                    end
                end
                S_FETCH: begin
                    if (line.kind == K_CALL) begin
                        if (in_sub) begin
                            nest_err <= 1'b1;
                        end else begin
                            ret_pc <= LINE_AW'(pc + 1'b1);
                            in_sub <= 1'b1;
                            pc     <= line.callee;
                        end
                    end else if (line.kind == K_BLOCK) begin
                        cur_jtgt <= line.jtgt; cur_ret <= line.ret; cur_inf <= line.inf;
                        cur_rpt <= line.rpt; cur_jmode <= line.jmode;
                        wait_sel <= line.wsel; jump_sel <= line.jsel;
                        lvl <= line.lvl;
                        base <= blk.base; len_m1 <= blk.len_m1;
                        paddr <= blk.base; vcnt <= blk.len_m1; rcnt <= '0;
                    end
                end
                S_WAIT: ;
                S_PLAY: begin
                    if (!last_vec) begin
                        paddr <= paddr + PAT_AW'(1);
                        vcnt  <= vcnt - PAT_AW'(1);
                    end else if (!last_rep) begin
                        paddr <= base;
                        vcnt  <= len_m1;
                        rcnt  <= rcnt + RPT_W'(1);
                    end else if (take_jump) begin
                        pc <= cur_jtgt;
                    end else if (cur_ret) begin
                        pc     <= ret_pc;
                        in_sub <= 1'b0;
                    end else begin
                        pc <= LINE_AW'(pc + 1'b1);
                    end
                end
            endcase
        end
    end

    assign line_idx  = pc;
    assign blk_idx   = line.callee[BLK_AW-1:0];
    assign pat_addr  = paddr;
    assign pat_valid = (state == S_PLAY);
    assign running   = (state != S_IDLE);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && !last_vec && !stop) |=> (pat_valid && pat_addr == $past(pat_addr) + PAT_AW'(1)));
    p_rpt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PLAY && !cur_inf) |-> (rcnt <= cur_rpt));
    p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !wait_hit && !stop) |=> (state == S_WAIT));
    p_nest_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nest_err) |-> !running);
    p_stop_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!running && !pat_valid));
endmodule

// File: rtl/sbs_sequencer.sv
module sbs_sequencer
    import sbs_pkg::*;
#(
    parameter int NUM_LINES = 1 << LINE_AW,
    parameter int NUM_BLKS  = 1 << BLK_AW,
    parameter int NUM_COND  = 1 << COND_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_kind,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0]  wr_data,
    input  logic               start,
    input  logic               stop,
    input  logic               step_mode,
    input  logic               step_go,
    input  logic [EVT_W-1:0]   evt,
    input  logic [SIG_AW-1:0]  sig_sel,
    output logic [PAT_AW-1:0]  pat_addr,
    output logic               pat_valid,
    output logic [SIG_N-1:0]   im_sig,
    output logic               running,
    output logic               nest_err
);
    line_t              cur_line;
    blk_t               cur_blk;
    logic [LINE_AW-1:0] line_idx;
    logic [BLK_AW-1:0]  blk_idx;
    logic [COND_AW-1:0] wait_sel, jump_sel;
    logic [1:0]         hits;
    logic               lvl;

    sbs_line_store #(.NUM_LINES(NUM_LINES), .NUM_BLKS(NUM_BLKS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_addr(wr_addr[LINE_AW-1:0]), .wr_data(wr_data),
        .rd_line_idx(line_idx), .rd_line(cur_line),
        .rd_blk_idx(blk_idx), .rd_blk(cur_blk)
    );

    sbs_cond_eval #(.NUM_COND(NUM_COND), .NQ(2)) u_cond (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data[7:0]), .evt(evt),
        .force_hit(step_mode & step_go),
        .q_sel({jump_sel, wait_sel}), .q_hit(hits)
    );

    sbs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .line(cur_line), .blk(cur_blk),
        .wait_hit(hits[0]), .jump_hit(hits[1]),
        .line_idx(line_idx), .blk_idx(blk_idx),
        .wait_sel(wait_sel), .jump_sel(jump_sel),
        .pat_addr(pat_addr), .pat_valid(pat_valid), .lvl(lvl),
        .running(running), .nest_err(nest_err)
    );

    always_comb begin
        im_sig = '0;
        im_sig[sig_sel] = lvl & running;
    end

    p_sig_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(im_sig));
    p_sig_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (im_sig == '0));
endmodule

// File: tb/sbs_sequencer_tb.sv
module sbs_sequencer_tb_top;
    import sbs_pkg::*;

    localparam int CLK_P = 10;
    localparam int WDOG  = 190000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [1:0]         wr_kind = '0;
    logic [WADDR_W-1:0] wr_addr = '0;
    logic [LINE_W-1:0]  wr_data = '0;
    logic               start = 1'b0, stop = 1'b0, step_mode = 1'b0, step_go = 1'b0;
    logic [EVT_W-1:0]   evt = '0;
    logic [SIG_AW-1:0]  sig_sel = '0;
    logic [PAT_AW-1:0]  pat_addr;
    logic               pat_valid;
    logic [SIG_N-1:0]   im_sig;
    logic               running, nest_err;

    sbs_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .stop(stop), .step_mode(step_mode),
        .step_go(step_go), .evt(evt), .sig_sel(sig_sel), .pat_addr(pat_addr),
        .pat_valid(pat_valid), .im_sig(im_sig), .running(running), .nest_err(nest_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    logic [PAT_AW-1:0] got_a [256];
    logic [SIG_N-1:0]  got_s [256];
    logic [PAT_AW-1:0] exp_a [256];
    logic [SIG_N-1:0]  exp_s [256];
    int n_got, n_exp, n80;

    always @(posedge clk) begin
        cycles++;
        if (cycles == WDOG) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int a, input logic [LINE_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_addr = WADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [LINE_W-1:0] mk(input int kind, input bit ret, input bit lvl,
        input bit wen, input int wsel, input int jmode, input int jsel, input bit inf,
        input int rpt, input int callee, input int jtgt);
        logic [LINE_W-1:0] w;
        w = '0;
        w[1:0] = 2'(kind); w[2] = ret; w[3] = lvl; w[4] = wen; w[6:5] = 2'(wsel);
        w[8:7] = 2'(jmode); w[10:9] = 2'(jsel); w[11] = inf; w[27:12] = 16'(rpt);
        w[31:28] = 4'(callee); w[35:32] = 4'(jtgt);
        return w;
    endfunction

    task automatic blk_line(input int idx, input int b, input int rpt, input bit lvl);
        wr(WR_LINE, idx, mk(0, 0, lvl, 0, 0, 0, 0, 0, rpt, b, 0));
    endtask

    task automatic end_line(input int idx);
        wr(WR_LINE, idx, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic push(input int base, input int len, input int reps, input bit lvl);
        for (int r = 0; r < reps; r++)
            for (int v = 0; v < len; v++) begin
                exp_a[n_exp] = PAT_AW'(base + v);
                exp_s[n_exp] = lvl ? SIG_N'(1) << sig_sel : '0;
                n_exp++;
            end
    endtask

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic collect(input int maxn, input int tmo);
        int t;
        n_got = 0; n80 = 0; t = 0;
        while (n_got < maxn && t < tmo) begin
            if (pat_valid) begin
                if (n_got < 256) begin got_a[n_got] = pat_addr; got_s[n_got] = im_sig; end
                if (pat_addr == 8'h80) n80++;
                n_got++;
            end
            if (!running || n_got >= maxn) break;
            @(negedge clk);
            t++;
        end
        chk(t < tmo, "collect timeout", t, tmo);
    endtask

    task automatic compare(input string req);
        int bad;
        bad = -1;
        chk(n_got == n_exp, {req, " stream length"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            if (bad < 0 && (got_a[i] !== exp_a[i] || got_s[i] !== exp_s[i])) bad = i;
        if (bad >= 0)
            chk(1'b0, {req, " stream element"}, {got_s[bad], got_a[bad]}, {exp_s[bad], exp_a[bad]});
        else
            chk(1'b1, req, 0, 0);
    endtask

    task automatic do_stop(input string req);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(!running && !pat_valid, req, {running, pat_valid}, 0);
    endtask

    task automatic s2_prog();
        blk_line(0, 2, 0, 0);
        wr(WR_LINE, 1, mk(0, 0, 0, 0, 0, 2, 0, 0, 1, 0, 3));
        blk_line(2, 1, 0, 0);
        blk_line(3, 3, 0, 0);
        end_line(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(!pat_valid && !running && im_sig == 0 && !nest_err, "R1 reset state",
            {pat_valid, running, im_sig, nest_err}, 0);

        // block table: b0 0x10 len3, b1 0x40 len2, b2 0x80 len1, b3 0xF0 len4
        wr(WR_BLK, 0, 36'h0_0000_0210);
        wr(WR_BLK, 1, 36'h0_0000_0140);
        wr(WR_BLK, 2, 36'h0_0000_0080);
        wr(WR_BLK, 3, 36'h0_0000_03F0);

        // R1 R2 R3 R5 R9: order, repeat, end, signal level on selected bit
        sig_sel = 2;
        blk_line(0, 1, 2, 1);
        blk_line(1, 0, 0, 0);
        end_line(2);
        go(); collect(200, 200);
        n_exp = 0; push(8'h40, 2, 3, 1); push(8'h10, 3, 1, 0);
        compare("R1 R2 R3 R9 sequential play");
        chk(!running && !pat_valid && im_sig == 0, "R5 end line halts", {running, pat_valid, im_sig}, 0);

        // R7: conditional jump, table 0 true when event bit 3 set
        sig_sel = 0;
        for (int b = 0; b < 32; b++) wr(WR_COND, b, ((b % 2) == 1) ? 36'hFF : 36'h00);
        s2_prog();
        evt = 8'h08; go(); collect(200, 200);
        n_exp = 0; push(8'h80, 1, 1, 0); push(8'h10, 3, 2, 0); push(8'hF0, 4, 1, 0);
        compare("R7 jump taken");
        evt = 8'h00; go(); collect(200, 200);
        n_exp = 0; push(8'h80, 1, 1, 0); push(8'h10, 3, 2, 0); push(8'h40, 2, 1, 0); push(8'hF0, 4, 1, 0);
        compare("R7 jump not taken, zero events");
        evt = 8'hF7; go(); collect(200, 200);
        compare("R7 jump not taken, other bits set");

        // R10: step mode forces the conditional jump
        evt = 8'h00; step_mode = 1'b1; step_go = 1'b1;
        go(); collect(200, 200);
        n_exp = 0; push(8'h80, 1, 1, 0); push(8'h10, 3, 2, 0); push(8'hF0, 4, 1, 0);
        compare("R10 step forces jump");
        step_mode = 1'b0; step_go = 1'b0;

        // R8 R13: prologue then unconditional loop, stopped
        blk_line(0, 2, 0, 0);
        wr(WR_LINE, 1, mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1));
        go(); collect(9, 100);
        n_exp = 0; push(8'h80, 1, 1, 0); push(8'h40, 2, 4, 0);
        compare("R8 prologue then loop");
        do_stop("R13 stop ends loop");

        // R4 R13: infinite repeat
        wr(WR_LINE, 0, mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0));
        go(); collect(20, 100);
        n_exp = 0; push(8'h80, 1, 20, 0);
        compare("R4 infinite repeat");
        do_stop("R13 stop ends infinite repeat");

        // R6: gate, table 1 true only for event 0xA5
        wr(WR_COND, 32 + 20, 36'h20);
        wr(WR_LINE, 0, mk(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0));
        end_line(1);
        evt = 8'h00; go();
        begin
            int leaks = 0;
            for (int i = 0; i < 15; i++) begin
                if (pat_valid || !running) leaks++;
                if (i == 8) evt = 8'hA4;
                @(negedge clk);
            end
            chk(leaks == 0, "R6 gate held closed", leaks, 0);
        end
        evt = 8'hA5; collect(200, 200);
        n_exp = 0; push(8'h10, 3, 1, 0);
        compare("R6 gate opens on match");

        // R10: step_go ignored without step mode, then opens gate with it
        evt = 8'h00; go();
        @(negedge clk); step_go = 1'b1;
        @(negedge clk); step_go = 1'b0;
        begin
            int leaks = 0;
            for (int i = 0; i < 4; i++) begin
                if (pat_valid || !running) leaks++;
                @(negedge clk);
            end
            chk(leaks == 0, "R10 step_go ignored when step mode off", leaks, 0);
        end
        step_mode = 1'b1; step_go = 1'b1;
        @(negedge clk); step_go = 1'b0;
        collect(200, 200);
        compare("R10 step opens gate");
        step_mode = 1'b0;

        // R12: nested call
        wr(WR_LINE, 0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0));
        wr(WR_LINE, 5, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 8, 0));
        go(); collect(50, 50);
        chk(n_got == 0 && nest_err && !running, "R12 nested call halts with error",
            {n_got[7:0], nest_err, running}, 9'h02);

        // R11 R9: call and return, signal on bit 0
        blk_line(1, 2, 0, 0);
        end_line(2);
        blk_line(5, 1, 0, 1);
        wr(WR_LINE, 6, mk(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        go();
        chk(!nest_err, "R12 start clears error", nest_err, 0);
        collect(200, 200);
        n_exp = 0; push(8'h40, 2, 1, 1); push(8'h10, 3, 1, 0); push(8'h80, 1, 1, 0);
        compare("R11 R9 call and return");

        // R3: maximum repeat count 65536
        wr(WR_LINE, 0, mk(0, 0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 2, 0));
        blk_line(1, 3, 0, 0);
        end_line(2);
        go(); collect(70000, 70100);
        chk(n80 == 65536, "R3 repeat 65536 count", n80, 65536);
        chk(n_got == 65540, "R3 repeat 65536 total", n_got, 65540);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule